// File: doc/BRIEF.md
# NAND DDR Device-Side Bus Decoder

This block sits on the device side of an 8-bit multiplexed NAND-style bus. It does not use any of the host strobes as a clock. Chip enable, the two latch-select lines, the write strobe, the data strobe, the read strobe and the data bus are sampled by the system clock through one shared two-flop synchroniser. Edges are then found by comparing each sampled value with the one from the cycle before. The latch-select pair decides what a write-strobe rising edge carries: a command byte, an address byte, or an illegal cycle that is dropped and flagged. Write data is captured on every edge of the incoming data strobe while both latch selects are low.

Reads are driven by the host's read strobe. Each edge of the read strobe, rising or falling, pulls one byte from a byte-source interface. That byte then goes through a fixed-latency pipe before it is driven out, together with an outgoing strobe that toggles once per byte. The output drivers are enabled only during a read data phase. Captured commands, addresses and data leave on three separate one-cycle valid streams.

Top module: `nand_bus_decoder`

## Requirements
- R1: With chip enable low (`ce_n`=0), `cle`=1 and `ale`=0, a rising edge on `we_n` yields one `cmd_valid` pulse, with `cmd_byte` equal to `dq_in`.
- R2: With chip enable low, `cle`=0 and `ale`=1, a rising edge on `we_n` yields one `addr_valid` pulse, with `addr_byte` equal to `dq_in`.
- R3: With chip enable low and both `cle` and `ale` low, every rising and every falling edge of `dqs_in` yields one `data_valid` pulse carrying `dq_in`. A `we_n` rising edge in this state produces no output.
- R4: A `we_n` rising edge with both `cle` and `ale` high yields one `err_pulse` and no command, address or data pulse.
- R5: While `ce_n` is high, edges on `we_n`, `dqs_in` and `re_n` produce no output pulse, no `rd_req`, and no driver enable.
- R6: With chip enable low and both latch selects low, each edge of `re_n` (either direction) raises `rd_req` for exactly one cycle. That cycle consumes the byte offered on `rd_byte`.
- R7: A consumed byte appears on `dq_out` exactly 3+RD_LAT clock edges after the first edge that samples the `re_n` change (5 edges with the default RD_LAT=2). Bytes leave in the order they were consumed.
- R8: `dqs_out` is 0 when the drivers are disabled. It toggles once with every byte placed on `dq_out`, so the first byte of a read phase goes out with `dqs_out`=1.
- R9: `drv_en` is 0 after reset and rises with the first read byte. It falls, and `dqs_out` returns to 0, within 3 clock edges once `ce_n`, `cle` or `ale` goes high.
- R10: `cmd_valid`, `addr_valid`, `data_valid` and `err_pulse` are high in the cycle that follows the third clock edge after the strobe change.
- R11: After reset, every valid pulse, `err_pulse`, `rd_req`, `drv_en` and `dqs_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Host write strobe; command/address taken on its rise |
| re_n | input | 1 | Host read strobe; every edge requests one byte |
| dqs_in | input | 1 | True leg of the host data strobe |
| dq_in | input | 8 | Bus value seen from the host |
| dq_out | output | 8 | Read byte to drive onto the bus |
| dqs_out | output | 1 | Outgoing read strobe |
| drv_en | output | 1 | Driver enable for dq_out and dqs_out |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_byte | output | 8 | Captured command |
| addr_valid | output | 1 | One-cycle address pulse |
| addr_byte | output | 8 | Captured address byte |
| data_valid | output | 1 | One-cycle write-data pulse |
| data_byte | output | 8 | Captured write byte |
| err_pulse | output | 1 | Illegal latch-select combination seen |
| rd_req | output | 1 | Consume strobe for the byte source |
| rd_byte | input | 8 | Next read byte from the byte source |

## Verification
Every input strobe goes through two synchroniser flops and one edge flop. The command, address, data and error pulses therefore show up after the third clock edge that follows a host change. A read byte needs RD_LAT more edges on top of that, so it reaches `dq_out` after the fifth edge. The bench drives each change at a falling edge and counts falling edges after it. The latency check looks for the pulse at exactly the third sample, and the read test reads `dq_out` at the fifth sample after confirming it is still idle at the fourth. Pulse streams are logged on each rising edge, so the content checks do not depend on when the bench samples.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

  typedef enum logic [1:0] {
    XFER_DATA = 2'b00,
    XFER_ADDR = 2'b01,
    XFER_CMD  = 2'b10,
    XFER_BAD  = 2'b11
  } xfer_t;

  // Meaning of a bus transfer from the {cle, ale} pair.
  function automatic xfer_t classify(input logic cle, input logic ale);
    return xfer_t'({cle, ale});
  endfunction

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic any_edge(input logic cur, input logic prev);
    return cur ^ prev;
  endfunction

endpackage

// File: rtl/nand_sync.sv
module nand_sync #(
  parameter int         W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST;
      q      <= RST;
      q_prev <= RST;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/nand_latch_decode.sv
module nand_latch_decode
  import nand_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_ce_n,
  input  logic          s_cle,
  input  logic          s_ale,
  input  logic [DW-1:0] s_dq,
  input  logic          we_rise,
  input  logic          dqs_edge,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_byte,
  output logic          addr_valid,
  output logic [DW-1:0] addr_byte,
  output logic          data_valid,
  output logic [DW-1:0] data_byte,
  output logic          err_pulse
);
  xfer_t kind;
  assign kind = classify(s_cle, s_ale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      addr_valid <= 1'b0;
      data_valid <= 1'b0;
      err_pulse  <= 1'b0;
      cmd_byte   <= '0;
      addr_byte  <= '0;
      data_byte  <= '0;
    end else begin
      cmd_valid  <= 1'b0;
      addr_valid <= 1'b0;
      data_valid <= 1'b0;
      err_pulse  <= 1'b0;
      if (!s_ce_n) begin
        if (we_rise) begin
          unique case (kind)
            XFER_CMD: begin
              cmd_valid <= 1'b1;
              cmd_byte  <= s_dq;
            end
            XFER_ADDR: begin
              addr_valid <= 1'b1;
              addr_byte  <= s_dq;
            end
            XFER_BAD:  err_pulse <= 1'b1;
            default:   ;
          endcase
        end
        if (dqs_edge && kind == XFER_DATA) begin
          data_valid <= 1'b1;
          data_byte  <= s_dq;
        end
      end
    end
  end
endmodule

// File: rtl/nand_read_pipe.sv
module nand_read_pipe #(
  parameter int DW  = 8,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] src_byte,
  input  logic          stop,
  output logic          fire,
  output logic [DW-1:0] dq_out,
  output logic          dqs_out,
  output logic          drv_en
);
  localparam int STAGES = (LAT < 1) ? 1 : LAT;

  logic [STAGES-1:0] vld;
  logic [DW-1:0]     byt [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      byt[0] <= '0;
    end else begin
      vld[0] <= take;
      byt[0] <= src_byte;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        byt[g] <= '0;
      end else begin
        vld[g] <= vld[g-1];
        byt[g] <= byt[g-1];
      end
    end
  end

  assign fire = vld[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out  <= '0;
      dqs_out <= 1'b0;
      drv_en  <= 1'b0;
    end else if (stop) begin
      dqs_out <= 1'b0;
      drv_en  <= 1'b0;
    end else if (fire) begin
      dq_out  <= byt[STAGES-1];
      dqs_out <= ~dqs_out;
      drv_en  <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
  import nand_dec_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic          re_n,
  input  logic          dqs_in,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dqs_out,
  output logic          drv_en,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_byte,
  output logic          addr_valid,
  output logic [DW-1:0] addr_byte,
  output logic          data_valid,
  output logic [DW-1:0] data_byte,
  output logic          err_pulse,
  output logic          rd_req,
  input  logic [DW-1:0] rd_byte
);
  localparam int SW = DW + 6;
  localparam logic [SW-1:0] SRST = {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, {DW{1'b0}}};

  logic [SW-1:0] raw, cur, prv;
  assign raw = {ce_n, cle, ale, we_n, dqs_in, re_n, dq_in};

  nand_sync #(.W(SW), .RST(SRST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(cur), .q_prev(prv)
  );

  logic s_ce_n, s_cle, s_ale, s_we, s_dqs, s_re;
  logic p_we, p_dqs, p_re;
  logic [DW-1:0] s_dq;
  assign {s_ce_n, s_cle, s_ale, s_we, s_dqs, s_re, s_dq} = cur;
  assign p_we  = prv[DW+2];
  assign p_dqs = prv[DW+1];
  assign p_re  = prv[DW];

  // Named internal events, used by the bound checker.
  logic evt_we_rise, evt_dqs_edge, evt_re_edge, evt_rd_fire, s_stop;
  assign evt_we_rise  = rise_of(s_we, p_we);
  assign evt_dqs_edge = any_edge(s_dqs, p_dqs);
  assign s_stop       = s_ce_n | s_cle | s_ale;
  assign evt_re_edge  = any_edge(s_re, p_re) & ~s_stop;
  assign rd_req       = evt_re_edge;

  nand_latch_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .s_ce_n(s_ce_n), .s_cle(s_cle), .s_ale(s_ale), .s_dq(s_dq),
    .we_rise(evt_we_rise), .dqs_edge(evt_dqs_edge),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte),
    .data_valid(data_valid), .data_byte(data_byte),
    .err_pulse(err_pulse)
  );

  nand_read_pipe #(.DW(DW), .LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .take(evt_re_edge), .src_byte(rd_byte), .stop(s_stop),
    .fire(evt_rd_fire), .dq_out(dq_out), .dqs_out(dqs_out), .drv_en(drv_en)
  );
endmodule

// File: rtl/nand_dec_chk.sv
module nand_dec_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ce_n,
  input logic          s_cle,
  input logic          s_ale,
  input logic [DW-1:0] s_dq,
  input logic          evt_we_rise,
  input logic          evt_dqs_edge,
  input logic          evt_rd_fire,
  input logic          s_stop,
  input logic          rd_req,
  input logic          cmd_valid,
  input logic [DW-1:0] cmd_byte,
  input logic          addr_valid,
  input logic [DW-1:0] addr_byte,
  input logic          data_valid,
  input logic [DW-1:0] data_byte,
  input logic          err_pulse,
  input logic          dqs_out,
  input logic          drv_en
);
  p_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we_rise && !s_ce_n && s_cle && !s_ale |=> cmd_valid && cmd_byte == $past(s_dq));

  p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we_rise && !s_ce_n && !s_cle && s_ale |=> addr_valid && addr_byte == $past(s_dq));

  p_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dqs_edge && !s_ce_n && !s_cle && !s_ale |=> data_valid && data_byte == $past(s_dq));

  p_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we_rise && !s_ce_n && s_cle && s_ale |=> err_pulse && !cmd_valid && !addr_valid);

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ce_n |=> !cmd_valid && !addr_valid && !data_valid && !err_pulse);

  p_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ce_n |-> !rd_req);

  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_fire && !s_stop |=> dqs_out != $past(dqs_out) && drv_en);

  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_stop |=> !drv_en && !dqs_out);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_valid, addr_valid, err_pulse}) <= 1);
endmodule

bind nand_bus_decoder nand_dec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ce_n(s_ce_n), .s_cle(s_cle), .s_ale(s_ale),
  .s_dq(s_dq), .evt_we_rise(evt_we_rise), .evt_dqs_edge(evt_dqs_edge),
  .evt_rd_fire(evt_rd_fire), .s_stop(s_stop), .rd_req(rd_req),
  .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .addr_valid(addr_valid),
  .addr_byte(addr_byte), .data_valid(data_valid), .data_byte(data_byte),
  .err_pulse(err_pulse), .dqs_out(dqs_out), .drv_en(drv_en)
);

// File: tb/tb_nand_bus_decoder.sv
`timescale 1ns/1ps
module tb_nand_bus_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, dqs_in = 1'b0;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out, cmd_byte, addr_byte, data_byte;
  logic dqs_out, drv_en, cmd_valid, addr_valid, data_valid, err_pulse, rd_req;
  logic [7:0] rd_byte;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nand_bus_decoder dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .dqs_in(dqs_in), .dq_in(dq_in), .dq_out(dq_out), .dqs_out(dqs_out),
    .drv_en(drv_en), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .data_valid(data_valid),
    .data_byte(data_byte), .err_pulse(err_pulse), .rd_req(rd_req), .rd_byte(rd_byte)
  );

  // Byte source and pulse logs.
  int rd_idx = 0, cmd_n = 0, addr_n = 0, data_n = 0, err_n = 0;
  logic [7:0] cmd_log [16];
  logic [7:0] addr_log [16];
  logic [7:0] data_log [16];
  assign rd_byte = 8'h30 + 8'(rd_idx);

  always @(posedge clk) begin
    if (rd_req) rd_idx <= rd_idx + 1;
    if (cmd_valid)  begin cmd_log[cmd_n[3:0]]   <= cmd_byte;  cmd_n  <= cmd_n + 1;  end
    if (addr_valid) begin addr_log[addr_n[3:0]] <= addr_byte; addr_n <= addr_n + 1; end
    if (data_valid) begin data_log[data_n[3:0]] <= data_byte; data_n <= data_n + 1; end
    if (err_pulse)  err_n <= err_n + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic we_pulse(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk);
    cle = c; ale = a; dq_in = v; we_n = 1'b0;
    idle(3);
    we_n = 1'b1;
    idle(5);
  endtask

  task automatic t_reset();
    idle(2);
    check("R11 cmd_valid", cmd_valid, 0);
    check("R11 drv_en", drv_en, 0);
    check("R11 dqs_out", dqs_out, 0);
    check("R11 rd_req/err", {rd_req, err_pulse, data_valid, addr_valid}, 0);
  endtask

  // R1 content plus R10 pulse latency.
  task automatic t_cmd_latency();
    int seen;
    seen = -1;
    @(negedge clk);
    ce_n = 1'b0; cle = 1'b1; ale = 1'b0; dq_in = 8'h80; we_n = 1'b0;
    idle(4);
    we_n = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (cmd_valid && seen < 0) seen = i;
    end
    check("R10 cmd pulse edge count", seen, 3);
    we_pulse(1'b1, 1'b0, 8'h10);
    check("R1 cmd count", cmd_n, 2);
    check("R1 cmd byte0", cmd_log[0], 8'h80);
    check("R1 cmd byte1", cmd_log[1], 8'h10);
  endtask

  task automatic t_addr();
    we_pulse(1'b0, 1'b1, 8'h1C);
    we_pulse(1'b0, 1'b1, 8'hE3);
    check("R2 addr count", addr_n, 2);
    check("R2 addr byte0", addr_log[0], 8'h1C);
    check("R2 addr byte1", addr_log[1], 8'hE3);
    check("R2 no cmd", cmd_n, 2);
  endtask

  task automatic t_data();
    int base;
    base = data_n;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); dq_in = 8'hA0 + 8'(k);
      @(negedge clk); dqs_in = ~dqs_in;
      idle(4);
    end
    check("R3 data count both edges", data_n - base, 4);
    for (int k = 0; k < 4; k++) check("R3 data byte", data_log[base + k], 8'hA0 + k);
    we_pulse(1'b0, 1'b0, 8'h55);
    check("R3 we with data select ignored", data_n - base + cmd_n + addr_n, 4 + 2 + 2);
  endtask

  task automatic t_illegal();
    we_pulse(1'b1, 1'b1, 8'h99);
    check("R4 err count", err_n, 1);
    check("R4 no cmd/addr", cmd_n + addr_n, 4);
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic t_ce_high();
    int c0, d0;
    c0 = cmd_n + addr_n + err_n; d0 = data_n;
    @(negedge clk); ce_n = 1'b1;
    we_pulse(1'b1, 1'b0, 8'h44);
    @(negedge clk); cle = 1'b0; dqs_in = ~dqs_in;
    idle(2); re_n = ~re_n;
    idle(8);
    check("R5 no cmd/addr/err", cmd_n + addr_n + err_n, c0);
    check("R5 no data", data_n, d0);
    check("R5 no byte consumed", rd_idx, 0);
    check("R5 drivers off", drv_en, 0);
  endtask

  task automatic t_read();
    @(negedge clk); ce_n = 1'b0; cle = 1'b0; ale = 1'b0;
    idle(4);
    for (int k = 0; k < 4; k++) begin
      re_n = ~re_n;
      idle(4);
      if (k == 0) check("R7 not before latency", drv_en, 0);
      @(negedge clk);
      check("R7 read byte", dq_out, 8'h30 + k);
      check("R8 strobe level", dqs_out, (k + 1) % 2);
      check("R9 drivers on", drv_en, 1);
    end
    check("R6 bytes consumed", rd_idx, 4);
    ce_n = 1'b1;
    idle(4);
    check("R9 drivers off after ce high", drv_en, 0);
    check("R8 strobe parked", dqs_out, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_cmd_latency();
    t_addr();
    t_data();
    t_illegal();
    t_ce_high();
    t_read();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule